// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block is the combinational integer execute stage of a 32-bit load-store processor. It receives the raw instruction word, the two source register values the caller has read, and the address of the instruction. It recognises its own class of instructions and produces the value to be written to the destination register in the same cycle. This class covers register-register arithmetic and logic, shifts by register or by immediate, twelve-bit immediate arithmetic and logic, and the two upper-immediate forms. Any other word is flagged as not belonging to the unit.

The caller uses the three register index outputs to read the register file. It must itself return zero for index 0, and it feeds the two values back on `src_a` (the value of the register at bits 9:5) and `src_b` (the value of the register at bits 14:10). Division, memory, branch and system instructions are decoded elsewhere and appear here as invalid.

Top module: `alu_exec`

## Requirements
- R1: With bits 31:21 zero, bits 20:15 equal to 100000 give src_a+src_b and 100010 give src_a-src_b, both modulo 2^32. The codes 101000, 101001, 101010 and 101011 give NOR, AND, OR and XOR of the two sources.
- R2: Register set-less-than (bits 20:15 = 100100 signed, 100101 unsigned, bits 31:21 zero) yields 1 when src_a is below src_b and 0 otherwise, zero-extended to 32 bits.
- R3: Register shifts (bits 20:15 = 101110 left logical, 101111 right logical, 110000 right arithmetic, bits 31:21 zero) shift src_a by src_b[4:0] only, and ignore the upper 27 bits of src_b.
- R4: Multiply forms (bits 20:15 = 111000 low word, 111001 signed high word, 111010 unsigned high word, bits 31:21 zero) return bits 31:0 or bits 63:32 of the 64-bit product of src_a and src_b.
- R5: When bits 31:18 equal 00000000010000, bits 17:15 = 000, 001 or 010 shift src_a left logical, right logical or right arithmetic by the 5-bit amount in bits 14:10.
- R6: When bits 31:26 are zero, bits 25:22 = 1010 add, 1000 signed-compare and 1001 unsigned-compare src_a with the sign-extended immediate in bits 21:10. The compares return 1 or 0.
- R7: When bits 31:26 are zero, bits 25:22 = 1101, 1110 and 1111 apply AND, OR and XOR of src_a with the zero-extended immediate in bits 21:10.
- R8: Bits 31:25 = 0001010 return the 20-bit field in bits 24:5 placed in result bits 31:12, with the low 12 bits zero. Bits 31:25 = 0001110 return that same value plus pc.
- R9: Any word that matches none of the above raises invalid and drives result to zero. This includes a register form with bit 21 set, an unlisted operation code, and an unlisted immediate opcode. A word that matches keeps invalid low.
- R10: rd_idx, rj_idx and rk_idx always equal instruction bits 4:0, 9:5 and 14:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| src_a | input | 32 | Value of register selected by bits 9:5 |
| src_b | input | 32 | Value of register selected by bits 14:10 |
| pc | input | 32 | Address of the instruction |
| result | output | 32 | Destination register value |
| invalid | output | 1 | Word is not an instruction of this unit |
| rd_idx | output | 5 | Destination register index |
| rj_idx | output | 5 | First source register index |
| rk_idx | output | 5 | Second source register index |

## Verification
The hardest cases to reach are the words that sit right next to valid encodings. Examples are a register form whose bit 21 is set, or a twelve-bit opcode that is left undefined. Each of these must be refused, and no partial result may leak out. The stimulus builds these words from the same field encoders as the valid ones, flips a single selecting bit, and holds non-zero sources so that any leak shows up. The shift cases put set bits above bit 4 of src_b, and the immediate cases use fields whose top bit is one, so that the sign-extension and zero-extension rules give different answers.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   typedef enum logic [3:0] {
      OP_NONE, OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_NOR, OP_AND, OP_OR,
      OP_XOR, OP_SLL, OP_SRL, OP_SRA, OP_MUL, OP_MULH, OP_MULHU
   } alu_op_e;

   typedef enum logic [1:0] {
      A_REG, A_PC, A_ZERO
   } a_sel_e;

   typedef enum logic [2:0] {
      B_REG, B_SIMM12, B_ZIMM12, B_SHAMT, B_UPPER
   } b_sel_e;

   typedef struct packed {
      alu_op_e op;
      a_sel_e  a_sel;
      b_sel_e  b_sel;
      logic    legal;
   } dec_t;

   // selector field encodings
   localparam logic [13:0] SHIMM_PREFIX = 14'b00000000010000;
   localparam logic [6:0]  UPPER_LOAD   = 7'b0001010;
   localparam logic [6:0]  UPPER_PCREL  = 7'b0001110;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_exec_pkg::*;
(
   input  logic [31:15] opc,
   output dec_t         dec
);
   logic [5:0] fn6;
   logic [3:0] op4;
   logic [2:0] sub3;

   assign fn6  = opc[20:15];
   assign op4  = opc[25:22];
   assign sub3 = opc[17:15];

   always_comb begin
      dec = '{op: OP_NONE, a_sel: A_REG, b_sel: B_REG, legal: 1'b0};
      if (opc[31:21] == 11'd0) begin
         dec.legal = 1'b1;
         unique case (fn6)
            6'b100000: dec.op = OP_ADD;
            6'b100010: dec.op = OP_SUB;
            6'b100100: dec.op = OP_SLT;
            6'b100101: dec.op = OP_SLTU;
            6'b101000: dec.op = OP_NOR;
            6'b101001: dec.op = OP_AND;
            6'b101010: dec.op = OP_OR;
            6'b101011: dec.op = OP_XOR;
            6'b101110: dec.op = OP_SLL;
            6'b101111: dec.op = OP_SRL;
            6'b110000: dec.op = OP_SRA;
            6'b111000: dec.op = OP_MUL;
            6'b111001: dec.op = OP_MULH;
            6'b111010: dec.op = OP_MULHU;
            default:   dec.legal = 1'b0;
         endcase
      end else if (opc[31:18] == SHIMM_PREFIX) begin
         dec.legal = 1'b1;
         dec.b_sel = B_SHAMT;
         unique case (sub3)
            3'b000:  dec.op = OP_SLL;
            3'b001:  dec.op = OP_SRL;
            3'b010:  dec.op = OP_SRA;
            default: dec.legal = 1'b0;
         endcase
      end else if (opc[31:26] == 6'd0) begin
         dec.legal = 1'b1;
         dec.b_sel = B_SIMM12;
         unique case (op4)
            4'b1000: dec.op = OP_SLT;
            4'b1001: dec.op = OP_SLTU;
            4'b1010: dec.op = OP_ADD;
            4'b1101: begin dec.op = OP_AND; dec.b_sel = B_ZIMM12; end
            4'b1110: begin dec.op = OP_OR;  dec.b_sel = B_ZIMM12; end
            4'b1111: begin dec.op = OP_XOR; dec.b_sel = B_ZIMM12; end
            default: dec.legal = 1'b0;
         endcase
      end else if (opc[31:25] == UPPER_LOAD) begin
         dec = '{op: OP_ADD, a_sel: A_ZERO, b_sel: B_UPPER, legal: 1'b1};
      end else if (opc[31:25] == UPPER_PCREL) begin
         dec = '{op: OP_ADD, a_sel: A_PC, b_sel: B_UPPER, legal: 1'b1};
      end
      if (!dec.legal) begin
         dec.op = OP_NONE;
      end
   end
endmodule

// File: rtl/alu_operand.sv
module alu_operand
   import alu_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [24:5]     imm_field,
   input  a_sel_e          a_sel,
   input  b_sel_e          b_sel,
   input  logic [XLEN-1:0] rs_a,
   input  logic [XLEN-1:0] rs_b,
   input  logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] op_a,
   output logic [XLEN-1:0] op_b
);
   localparam int IMM12_W = 12;
   localparam int SHAMT_W = $clog2(XLEN);

   logic [IMM12_W-1:0] imm12;
   logic [SHAMT_W-1:0] shamt;

   assign imm12 = imm_field[21:10];
   assign shamt = imm_field[10 +: SHAMT_W];

   always_comb begin
      unique case (a_sel)
         A_PC:    op_a = pc;
         A_ZERO:  op_a = '0;
         default: op_a = rs_a;
      endcase
   end

   always_comb begin
      unique case (b_sel)
         B_SIMM12: op_b = {{(XLEN-IMM12_W){imm12[IMM12_W-1]}}, imm12};
         B_ZIMM12: op_b = {{(XLEN-IMM12_W){1'b0}}, imm12};
         B_SHAMT:  op_b = {{(XLEN-SHAMT_W){1'b0}}, shamt};
         B_UPPER:  op_b = {imm_field[24:5], {IMM12_W{1'b0}}};
         default:  op_b = rs_b;
      endcase
   end
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_exec_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int MUL_STYLE   = 0,   // 0: one shared signed multiplier, 1: separate signed and unsigned
   parameter int SHIFT_STYLE = 0    // 0: shift operators, 1: explicit log stages
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   localparam int SHAMT_W = $clog2(XLEN);
   localparam int PROD_W  = 2 * XLEN;

   logic [SHAMT_W-1:0] amt;
   logic [XLEN-1:0]    sll_v, srl_v, sra_v;
   logic [XLEN-1:0]    mul_lo, mul_hi;
   logic               lt_s, lt_u;

   assign amt  = b[SHAMT_W-1:0];
   assign lt_s = $signed(a) < $signed(b);
   assign lt_u = a < b;

   generate
      if (SHIFT_STYLE == 0) begin : g_shift_op
         assign sll_v = a << amt;
         assign srl_v = a >> amt;
         assign sra_v = XLEN'($signed(a) >>> amt);
      end else begin : g_shift_log
         always_comb begin
            sll_v = a;
            srl_v = a;
            sra_v = a;
            for (int s = 0; s < SHAMT_W; s++) begin
               if (amt[s]) begin
                  sll_v = sll_v << (1 << s);
                  srl_v = srl_v >> (1 << s);
                  sra_v = (sra_v >> (1 << s))
                        | (a[XLEN-1] ? ~({XLEN{1'b1}} >> (1 << s)) : '0);
               end
            end
         end
      end

      if (MUL_STYLE == 0) begin : g_mul_shared
         logic              sgn;
         logic signed [XLEN:0]   ma, mb;
         logic signed [PROD_W-1:0] prod;
         assign sgn    = (op == OP_MULH);
         assign ma     = {sgn & a[XLEN-1], a};
         assign mb     = {sgn & b[XLEN-1], b};
         assign prod   = ma * mb;
         assign mul_lo = prod[XLEN-1:0];
         assign mul_hi = prod[PROD_W-1:XLEN];
      end else begin : g_mul_split
         logic signed [PROD_W-1:0] prod_s;
         logic [PROD_W-1:0]        prod_u;
         assign prod_s = $signed(a) * $signed(b);
         assign prod_u = a * b;
         assign mul_lo = prod_u[XLEN-1:0];
         assign mul_hi = (op == OP_MULH) ? prod_s[PROD_W-1:XLEN] : prod_u[PROD_W-1:XLEN];
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_ADD:   y = a + b;
         OP_SUB:   y = a - b;
         OP_SLT:   y = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:  y = {{(XLEN-1){1'b0}}, lt_u};
         OP_NOR:   y = ~(a | b);
         OP_AND:   y = a & b;
         OP_OR:    y = a | b;
         OP_XOR:   y = a ^ b;
         OP_SLL:   y = sll_v;
         OP_SRL:   y = srl_v;
         OP_SRA:   y = sra_v;
         OP_MUL:   y = mul_lo;
         OP_MULH,
         OP_MULHU: y = mul_hi;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_exec_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int IDX_W       = 5,
   parameter int MUL_STYLE   = 0,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [31:0]      insn,
   input  logic [XLEN-1:0]  src_a,
   input  logic [XLEN-1:0]  src_b,
   input  logic [XLEN-1:0]  pc,
   output logic [XLEN-1:0]  result,
   output logic             invalid,
   output logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] rj_idx,
   output logic [IDX_W-1:0] rk_idx
);
   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("alu_exec: encoding fixes XLEN to 32");
      end
      if (IDX_W != 5) begin : g_bad_idx
         $error("alu_exec: register index fields are 5 bits wide");
      end
      if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_mul
         $error("alu_exec: MUL_STYLE must be 0 or 1");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_bad_shift
         $error("alu_exec: SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   dec_t            dec;
   logic [XLEN-1:0] op_a, op_b, core_y;

   assign rd_idx = insn[IDX_W-1:0];
   assign rj_idx = insn[IDX_W +: IDX_W];
   assign rk_idx = insn[2*IDX_W +: IDX_W];

   alu_decode u_dec (
      .opc (insn[31:15]),
      .dec (dec)
   );

   alu_operand #(.XLEN(XLEN)) u_opnd (
      .imm_field (insn[24:5]),
      .a_sel     (dec.a_sel),
      .b_sel     (dec.b_sel),
      .rs_a      (src_a),
      .rs_b      (src_b),
      .pc        (pc),
      .op_a      (op_a),
      .op_b      (op_b)
   );

   alu_core #(.XLEN(XLEN), .MUL_STYLE(MUL_STYLE), .SHIFT_STYLE(SHIFT_STYLE)) u_core (
      .op (dec.op),
      .a  (op_a),
      .b  (op_b),
      .y  (core_y)
   );

   assign invalid = ~dec.legal;
   assign result  = dec.legal ? core_y : '0;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input logic [31:0]      insn,
   input logic [XLEN-1:0]  src_a,
   input logic [XLEN-1:0]  result,
   input logic             invalid,
   input logic [IDX_W-1:0] rd_idx,
   input logic [IDX_W-1:0] rj_idx,
   input logic [IDX_W-1:0] rk_idx
);
   always_comb begin
      // R9: a refused word never leaks a value
      a_r9_zero_when_invalid: assert (!invalid || result == '0)
         else $error("R9: invalid word produced non-zero result");

      // R10: index outputs follow the fixed fields
      a_r10_fields: assert (rd_idx == insn[4:0] && rj_idx == insn[9:5] && rk_idx == insn[14:10])
         else $error("R10: register index mismatch");

      // R8: upper-immediate load is accepted and clears the low 12 bits
      a_r8_upper_low_clear: assert (insn[31:25] != 7'b0001010 || (!invalid && result[11:0] == '0))
         else $error("R8: upper load result malformed");

      // R2: register compares give a single-bit answer
      a_r2_slt_boolean: assert (!(insn[31:21] == '0 && insn[20:16] == 5'b10010)
                                || (!invalid && result[XLEN-1:1] == '0))
         else $error("R2: compare result not 0/1");

      // R5: immediate shift by zero leaves the source untouched
      a_r5_zero_amount: assert (!(insn[31:18] == 14'b00000000010000 && insn[17:15] <= 3'd2
                                  && insn[14:10] == '0) || result == src_a)
         else $error("R5: zero-amount shift altered value");

      // R7: zero-extended AND immediate can set nothing above bit 11
      a_r7_andi_upper_zero: assert (!(insn[31:26] == '0 && insn[25:22] == 4'b1101)
                                    || (!invalid && result[XLEN-1:12] == '0))
         else $error("R7: AND immediate upper bits set");
   end
endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
   .insn    (insn),
   .src_a   (src_a),
   .result  (result),
   .invalid (invalid),
   .rd_idx  (rd_idx),
   .rj_idx  (rj_idx),
   .rk_idx  (rk_idx)
);

// File: tb/tb_alu_exec.sv
`timescale 1ns/1ps
module tb_alu_exec;
   logic        clk = 1'b0;
   logic [31:0] insn = '0, src_a = '0, src_b = '0, pc = '0;
   logic [31:0] result;
   logic        invalid;
   logic [4:0]  rd_idx, rj_idx, rk_idx;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   alu_exec dut (
      .insn(insn), .src_a(src_a), .src_b(src_b), .pc(pc),
      .result(result), .invalid(invalid),
      .rd_idx(rd_idx), .rj_idx(rj_idx), .rk_idx(rk_idx)
   );

   function automatic logic [31:0] enc_r(logic [5:0] f, logic [4:0] rd, logic [4:0] rj, logic [4:0] rk);
      return {11'd0, f, rk, rj, rd};
   endfunction
   function automatic logic [31:0] enc_si(logic [2:0] s, logic [4:0] amt);
      return {14'b00000000010000, s, amt, 5'd2, 5'd1};
   endfunction
   function automatic logic [31:0] enc_i(logic [3:0] o, logic [11:0] imm);
      return {6'd0, o, imm, 5'd2, 5'd1};
   endfunction
   function automatic logic [31:0] enc_u(logic [6:0] o, logic [19:0] imm);
      return {o, imm, 5'd1};
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
      end
   endtask

   task automatic apply(logic [31:0] i, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      insn = i; src_a = a; src_b = b;
      #1;
   endtask

   task automatic expect_ok(string req, string what, logic [31:0] exp);
      chk(req, {what, " result"}, result, exp);
      chk(req, {what, " invalid"}, {31'd0, invalid}, 32'd0);
   endtask

   task automatic t_idle;
      apply(32'd0, 32'h1234_5678, 32'h9abc_def0);
      chk("R9", "all-zero word invalid", {31'd0, invalid}, 32'd1);
      chk("R9", "all-zero word result", result, 32'd0);
   endtask

   task automatic t_r1_basic;
      logic [31:0] a = 32'hFFFF_FFFF, b = 32'h0000_0001, c = 32'hF0F0_1234;
      apply(enc_r(6'b100000, 1, 2, 3), a, b); expect_ok("R1", "add wrap", 32'd0);
      apply(enc_r(6'b100010, 1, 2, 3), 32'd0, b); expect_ok("R1", "sub wrap", 32'hFFFF_FFFF);
      apply(enc_r(6'b101000, 1, 2, 3), c, b); expect_ok("R1", "nor", ~(c | b));
      apply(enc_r(6'b101001, 1, 2, 3), c, 32'h0FF0_FF00); expect_ok("R1", "and", c & 32'h0FF0_FF00);
      apply(enc_r(6'b101010, 1, 2, 3), c, 32'h0FF0_FF00); expect_ok("R1", "or", c | 32'h0FF0_FF00);
      apply(enc_r(6'b101011, 1, 2, 3), c, 32'h0FF0_FF00); expect_ok("R1", "xor", c ^ 32'h0FF0_FF00);
   endtask

   task automatic t_r2_compare;
      apply(enc_r(6'b100100, 1, 2, 3), 32'hFFFF_FFFF, 32'd1); expect_ok("R2", "slt -1<1", 32'd1);
      apply(enc_r(6'b100101, 1, 2, 3), 32'hFFFF_FFFF, 32'd1); expect_ok("R2", "sltu max<1", 32'd0);
      apply(enc_r(6'b100101, 1, 2, 3), 32'd7, 32'd7); expect_ok("R2", "sltu equal", 32'd0);
   endtask

   task automatic t_r3_regshift;
      logic [31:0] a = 32'h8000_0001;
      apply(enc_r(6'b101110, 1, 2, 3), a, 32'hFFFF_FF24); expect_ok("R3", "sll low5", a << 4);
      apply(enc_r(6'b101111, 1, 2, 3), a, 32'hFFFF_FF24); expect_ok("R3", "srl low5", a >> 4);
      apply(enc_r(6'b110000, 1, 2, 3), a, 32'hFFFF_FF24); expect_ok("R3", "sra low5", 32'hF800_0000);
      apply(enc_r(6'b101110, 1, 2, 3), a, 32'h0000_0020); expect_ok("R3", "amount 32 is 0", a);
   endtask

   task automatic t_r4_mul;
      logic [31:0] pairs_a [3] = '{32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
      logic [31:0] pairs_b [3] = '{32'h0000_0002, 32'h7FFF_FFFF, 32'hFEDC_BA98};
      for (int k = 0; k < 3; k++) begin
         longint          ps = longint'($signed(pairs_a[k])) * longint'($signed(pairs_b[k]));
         longint unsigned pu = {32'd0, pairs_a[k]} * {32'd0, pairs_b[k]};
         apply(enc_r(6'b111000, 1, 2, 3), pairs_a[k], pairs_b[k]); expect_ok("R4", "mul low", pu[31:0]);
         apply(enc_r(6'b111001, 1, 2, 3), pairs_a[k], pairs_b[k]); expect_ok("R4", "mulh signed", ps[63:32]);
         apply(enc_r(6'b111010, 1, 2, 3), pairs_a[k], pairs_b[k]); expect_ok("R4", "mulh unsigned", pu[63:32]);
      end
   endtask

   task automatic t_r5_immshift;
      apply(enc_si(3'b000, 5'd31), 32'h8000_0003, 32'hFFFF_FFFF); expect_ok("R5", "slli 31", 32'h8000_0000);
      apply(enc_si(3'b001, 5'd31), 32'h8000_0000, 32'd0); expect_ok("R5", "srli 31", 32'd1);
      apply(enc_si(3'b010, 5'd31), 32'h8000_0000, 32'd0); expect_ok("R5", "srai 31", 32'hFFFF_FFFF);
      apply(enc_si(3'b010, 5'd0), 32'h8765_4321, 32'd9); expect_ok("R5", "srai 0", 32'h8765_4321);
      apply(enc_si(3'b011, 5'd1), 32'h8765_4321, 32'd9);
      chk("R9", "shift sub-op 011 invalid", {31'd0, invalid}, 32'd1);
   endtask

   task automatic t_r6_signed_imm;
      apply(enc_i(4'b1010, 12'hFFF), 32'd5, 32'd0); expect_ok("R6", "addi -1", 32'd4);
      apply(enc_i(4'b1000, 12'h800), 32'd0, 32'd0); expect_ok("R6", "slti 0<-2048", 32'd0);
      apply(enc_i(4'b1000, 12'h7FF), 32'hFFFF_F000, 32'd0); expect_ok("R6", "slti neg<2047", 32'd1);
      apply(enc_i(4'b1001, 12'hFFF), 32'd5, 32'd0); expect_ok("R6", "sltui vs sext max", 32'd1);
   endtask

   task automatic t_r7_zero_imm;
      apply(enc_i(4'b1101, 12'hFFF), 32'hFFFF_FFFF, 32'd0); expect_ok("R7", "andi", 32'h0000_0FFF);
      apply(enc_i(4'b1110, 12'h800), 32'd0, 32'd0); expect_ok("R7", "ori", 32'h0000_0800);
      apply(enc_i(4'b1111, 12'hFFF), 32'hF0F0_F0F0, 32'd0); expect_ok("R7", "xori", 32'hF0F0_FF0F);
   endtask

   task automatic t_r8_upper;
      @(negedge clk); pc = 32'h1C00_0004;
      apply(enc_u(7'b0001010, 20'h80001), 32'hDEAD_BEEF, 32'd0); expect_ok("R8", "upper load", 32'h8000_1000);
      apply(enc_u(7'b0001110, 20'hFFFFF), 32'hDEAD_BEEF, 32'd0); expect_ok("R8", "upper pc-relative", 32'h1BFF_F004);
   endtask

   task automatic t_r9_refused;
      logic [31:0] words [4] = '{
         {10'd0, 7'b1000000, 5'd3, 5'd2, 5'd1},   // bit 21 set
         enc_r(6'b100001, 1, 2, 3),               // unlisted op code
         enc_r(6'b100000, 1, 2, 3) | 32'h8000_0000,
         enc_i(4'b1011, 12'h123)                  // unlisted immediate opcode
      };
      for (int k = 0; k < 4; k++) begin
         apply(words[k], 32'hFFFF_FFFF, 32'hFFFF_FFFF);
         chk("R9", "near-miss invalid", {31'd0, invalid}, 32'd1);
         chk("R9", "near-miss result", result, 32'd0);
      end
   endtask

   task automatic t_r10_idx;
      apply(enc_r(6'b100000, 5'd3, 5'd17, 5'd30), 32'd0, 32'd0);
      chk("R10", "rd", {27'd0, rd_idx}, 32'd3);
      chk("R10", "rj", {27'd0, rj_idx}, 32'd17);
      chk("R10", "rk", {27'd0, rk_idx}, 32'd30);
   endtask

   initial begin
      t_idle;
      t_r1_basic;
      t_r2_compare;
      t_r3_regshift;
      t_r4_mul;
      t_r5_immshift;
      t_r6_signed_imm;
      t_r7_zero_imm;
      t_r8_upper;
      t_r9_refused;
      t_r10_idx;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule